// File: doc/BRIEF.md
# Edge-Selectable Serial Shift Port

This block is the receive and echo stage of a three-wire serial port. A host frames a transfer by pulling chip-select low and sends bits on the serial data line. The block captures one bit on every rising serial-clock edge, most significant bit first, into a shift register whose width is a parameter (16 by default). When chip-select returns high, the collected word is handed to a downstream command decoder together with a one-cycle valid strobe. The strobe is given only if the frame held exactly the expected number of rising clock edges.

Each bit pushed out of the top of the shift register goes to a serial data output. Devices can then be chained, or the host can read back what it wrote. A select input sets when that output moves. When the select is high, the output changes on the rising serial-clock edge and trails the input by a full word of clocks. When it is low, the output changes on the falling edge and trails by a word plus half a clock. The register is not cleared between frames, so the first bits echoed in a new frame are the top bits of the previous word.

All port inputs are sampled by a fast on-chip clock through synchronizer stages, and edges are found by comparing successive samples. An active-low clear empties every register.

Top module: `edge_shift_port`

## Requirements
- R1: While chip-select is low, each rising serial-clock edge shifts the data input into the register LSB, so the first bit sent ends up in `word_o[15]` and the last in `word_o[0]`.
- R2: While chip-select is high, serial-clock edges and the data input have no effect: the register keeps its contents and `dout` holds its value.
- R3: On the rising edge of chip-select after exactly 16 rising serial-clock edges, `word_o` takes the assembled word and `word_valid` is high for exactly one clock cycle.
- R4: A frame with fewer or more than 16 rising serial-clock edges produces no `word_valid` pulse and leaves `word_o` unchanged.
- R5: The bit count restarts at each falling edge of chip-select. A 16-bit word sent as two 8-bit bursts, with chip-select held low through the pause, is accepted.
- R6: With `dout_rise_sel` = 1, `dout` changes only on rising serial-clock edges, where it takes the bit shifted out of the register MSB. This gives a lag of 16 clocks from the data input.
- R7: With `dout_rise_sel` = 0, `dout` changes only on falling serial-clock edges, where it takes the bit shifted out on the preceding rising edge. This gives a lag of 16.5 clocks.
- R8: The register keeps its contents between frames, so the `dout` bits of a new frame are the previous word, MSB first.
- R9: While `clr_n` is low, `dout`, `word_o` and `word_valid` are 0 and the shift register is emptied.
- R10: `word_o` changes only in a cycle in which `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| clr_n | input | 1 | Active-low asynchronous clear |
| cs_n | input | 1 | Active-low chip-select framing a transfer |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| dout_rise_sel | input | 1 | 1: dout moves on rising sclk; 0: on falling sclk |
| dout | output | 1 | Serial data output (echo / chain) |
| word_o | output | 16 | Last accepted word |
| word_valid | output | 1 | One-cycle strobe when a full word is accepted |

## Verification
The assertions check on every cycle that `word_valid` is a single-cycle pulse that follows a chip-select rise with a full bit count. They also check that `word_o` moves only with the strobe. Finally, they check that `dout` holds still while chip-select is high and only moves on the serial-clock edge the select chooses. The bench scenarios show the actual bit order and the 16 versus 16.5 clock echo lag. They also cover the carry-over of the previous word into the next frame's echo, the split-burst and wrong-length frames, and recovery after a clear in the middle of a frame.

// File: rtl/esp_pkg.sv
package esp_pkg;

  // Gated port events, one clock wide, derived from the synchronized inputs.
  typedef struct packed {
    logic shift_stb;  // rising sclk while selected
    logic fall_stb;   // falling sclk while selected
    logic cs_fall;    // frame start
    logic cs_rise;    // frame end
    logic cs_low;     // currently selected
  } port_ev_t;

  // Counter width able to hold 0..w+1 (w+1 marks "too many").
  function automatic int cnt_width(input int w);
    return $clog2(w + 2);
  endfunction

endpackage

// File: rtl/esp_sync.sv
module esp_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain <= INIT;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/esp_edge.sv
module esp_edge
  import esp_pkg::*;
(
  input  logic     clk,
  input  logic     clr_n,
  input  logic     sclk_s,
  input  logic     cs_n_s,
  output port_ev_t ev
);
  logic sclk_prev;
  logic cs_n_prev;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      sclk_prev <= 1'b0;
      cs_n_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_n_prev <= cs_n_s;
    end
  end

  always_comb begin
    ev.cs_low    = ~cs_n_s;
    ev.cs_fall   = cs_n_prev & ~cs_n_s;
    ev.cs_rise   = ~cs_n_prev & cs_n_s;
    ev.shift_stb = ~cs_n_s & sclk_s & ~sclk_prev;
    ev.fall_stb  = ~cs_n_s & ~sclk_s & sclk_prev;
  end
endmodule

// File: rtl/esp_shift_core.sv
module esp_shift_core #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              din_s,
  input  logic              shift_stb,
  input  logic              cs_fall,
  input  logic              cs_rise,
  output logic              out_bit,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] r,
                                                 input logic b);
    return {r[WORD_W-2:0], b};
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return (c == CNT_OVER) ? c : c + 1'b1;
  endfunction

  assign out_bit = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      word_o     <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (shift_stb) shreg <= push_bit(shreg, din_s);
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (shift_stb) begin
        bit_cnt <= cnt_step(bit_cnt);
      end
      if (cs_rise && bit_cnt == CNT_FULL) begin
        word_o     <= shreg;
        word_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/esp_dout.sv
module esp_dout (
  input  logic clk,
  input  logic clr_n,
  input  logic rise_sel,
  input  logic shift_stb,
  input  logic fall_stb,
  input  logic out_bit,
  output logic dout
);
  logic spill;

  // Next dout: rising mode echoes the bit leaving now, falling mode the
  // bit that left on the previous rising edge.
  function automatic logic pick(input logic sel, input logic sh, input logic fa,
                                input logic leaving, input logic held,
                                input logic cur);
    if (sel && sh)       return leaving;
    else if (!sel && fa) return held;
    else                 return cur;
  endfunction

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      spill <= 1'b0;
      dout  <= 1'b0;
    end else begin
      if (shift_stb) spill <= out_bit;
      dout <= pick(rise_sel, shift_stb, fall_stb, out_bit, spill, dout);
    end
  end
endmodule

// File: rtl/edge_shift_port.sv
module edge_shift_port
  import esp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              dout_rise_sel,
  output logic              dout,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid
);
  localparam int CNT_W = cnt_width(WORD_W);

  logic     sclk_s, cs_n_s, din_s;
  port_ev_t ev;
  logic     out_bit;
  logic [CNT_W-1:0] bit_cnt_w;

  // Named event wires for the checker.
  logic shift_stb_w, fall_stb_w, cs_fall_w, cs_rise_w, cs_low_w;
  assign shift_stb_w = ev.shift_stb;
  assign fall_stb_w  = ev.fall_stb;
  assign cs_fall_w   = ev.cs_fall;
  assign cs_rise_w   = ev.cs_rise;
  assign cs_low_w    = ev.cs_low;

  esp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sclk (
    .clk(clk), .clr_n(clr_n), .d(sclk), .q(sclk_s));
  esp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_cs (
    .clk(clk), .clr_n(clr_n), .d(cs_n), .q(cs_n_s));
  esp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_din (
    .clk(clk), .clr_n(clr_n), .d(din), .q(din_s));

  esp_edge u_edge (
    .clk(clk), .clr_n(clr_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .ev(ev));

  esp_shift_core #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .clr_n(clr_n), .din_s(din_s),
    .shift_stb(shift_stb_w), .cs_fall(cs_fall_w), .cs_rise(cs_rise_w),
    .out_bit(out_bit), .bit_cnt(bit_cnt_w),
    .word_o(word_o), .word_valid(word_valid));

  esp_dout u_dout (
    .clk(clk), .clr_n(clr_n), .rise_sel(dout_rise_sel),
    .shift_stb(shift_stb_w), .fall_stb(fall_stb_w),
    .out_bit(out_bit), .dout(dout));
endmodule

// File: rtl/esp_checker.sv
module esp_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              clr_n,
  input logic              rise_sel,
  input logic              dout,
  input logic [WORD_W-1:0] word_o,
  input logic              word_valid,
  input logic              shift_stb,
  input logic              fall_stb,
  input logic              cs_rise,
  input logic              cs_low,
  input logic [CNT_W-1:0]  bit_cnt
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!clr_n)
    word_valid |=> !word_valid);                                    // R3
  AST_VALID_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!clr_n)
    word_valid |-> $past(cs_rise));                                  // R3
  AST_VALID_NEEDS_FULL: assert property (@(posedge clk) disable iff (!clr_n)
    word_valid |-> $past(bit_cnt) == CNT_W'(WORD_W));                // R4
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!clr_n)
    !word_valid |-> $stable(word_o));                                // R10
  AST_DOUT_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!clr_n)
    !cs_low |=> $stable(dout));                                      // R2
  AST_DOUT_RISE_ONLY: assert property (@(posedge clk) disable iff (!clr_n)
    (rise_sel && !shift_stb) |=> $stable(dout));                     // R6
  AST_DOUT_FALL_ONLY: assert property (@(posedge clk) disable iff (!clr_n)
    (!rise_sel && !fall_stb) |=> $stable(dout));                     // R7
  AST_CLEAR_STATE: assert property (@(posedge clk)
    !clr_n |-> (!dout && !word_valid && word_o == '0));              // R9
endmodule

bind edge_shift_port esp_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .clr_n(clr_n), .rise_sel(dout_rise_sel), .dout(dout),
  .word_o(word_o), .word_valid(word_valid), .shift_stb(shift_stb_w),
  .fall_stb(fall_stb_w), .cs_rise(cs_rise_w), .cs_low(cs_low_w),
  .bit_cnt(bit_cnt_w));

// File: tb/edge_shift_port_bench.sv
module edge_shift_port_bench;
  localparam int W    = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic clr_n, cs_n, sclk, din, dout_rise_sel;
  logic dout, word_valid;
  logic [W-1:0] word_o;

  always #2 clk = ~clk;

  edge_shift_port u_edge_shift_port (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout_rise_sel(dout_rise_sel), .dout(dout),
    .word_o(word_o), .word_valid(word_valid));

  int checks = 0, fails = 0, vcnt = 0;
  logic [W-1:0] model, exp_word;
  logic exp_dout;
  bit finished = 0;

  always @(negedge clk) if (word_valid) vcnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits MSB first; checks dout after every edge against the model.
  task automatic run_frame(input logic [31:0] bits, input int n,
                           input int pause_at, input bit close, input string req);
    logic shifted, pend;
    int v0;
    v0 = vcnt;
    pend = 1'b0;
    cs_n = 1'b0; wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      din = bits[i]; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
      shifted = model[W-1];
      model = {model[W-2:0], bits[i]};
      if (dout_rise_sel) exp_dout = shifted; else pend = shifted;
      check(req, {31'd0, dout}, {31'd0, exp_dout});
      sclk = 1'b0; wait_clk(HALF);
      if (!dout_rise_sel) exp_dout = pend;
      check(req, {31'd0, dout}, {31'd0, exp_dout});
      if (n - i == pause_at) wait_clk(25);
    end
    if (close) begin
      cs_n = 1'b1; wait_clk(3 * HALF);
      if (n == W) begin
        exp_word = model;
        check("R3 valid pulse", vcnt - v0, 1);
        check("R1 R3 word", {16'd0, word_o}, {16'd0, exp_word});
      end else begin
        check("R4 no pulse", vcnt - v0, 0);
        check("R4 R10 word held", {16'd0, word_o}, {16'd0, exp_word});
      end
    end
  endtask

  task automatic t_reset;
    check("R9 dout after clear", {31'd0, dout}, 0);
    check("R9 word after clear", {16'd0, word_o}, 0);
    check("R9 no strobe", vcnt, 0);
  endtask

  task automatic t_basic;
    dout_rise_sel = 1'b0;
    run_frame(32'hA5C3, 16, 0, 1'b1, "R7 first frame echo");
    check("R1 first bit in MSB", {31'd0, word_o[15]}, 1);
    check("R1 last bit in LSB", {31'd0, word_o[0]}, 1);
  endtask

  task automatic t_modes;
    dout_rise_sel = 1'b1;
    run_frame(32'h3C96, 16, 0, 1'b1, "R6 R8 rising echo");
    dout_rise_sel = 1'b0;
    run_frame(32'h0F1E, 16, 0, 1'b1, "R7 R8 falling echo");
  endtask

  task automatic t_bursts;
    dout_rise_sel = 1'b1;
    run_frame(32'h8421, 16, 8, 1'b1, "R5 split bursts");
    check("R5 split word", {16'd0, word_o}, 32'h8421);
  endtask

  task automatic t_bad_length;
    dout_rise_sel = 1'b0;
    run_frame(32'h0ABC, 12, 0, 1'b1, "R4 short frame");
    dout_rise_sel = 1'b1;
    run_frame(32'hFEDCB, 20, 0, 1'b1, "R4 long frame");
  endtask

  task automatic t_deselected;
    int v0;
    v0 = vcnt;
    cs_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      din = 1'b1; wait_clk(HALF);
      sclk = 1'b1; wait_clk(HALF);
      check("R2 dout steady", {31'd0, dout}, {31'd0, exp_dout});
      sclk = 1'b0; wait_clk(HALF);
    end
    check("R2 no strobe", vcnt - v0, 0);
    dout_rise_sel = 1'b1;
    run_frame(32'h1234, 16, 0, 1'b1, "R2 R8 register untouched");
  endtask

  task automatic t_clear;
    int v0;
    v0 = vcnt;
    dout_rise_sel = 1'b0;
    run_frame(32'h001F, 5, 0, 1'b0, "R7 pre-clear");
    clr_n = 1'b0; cs_n = 1'b1; wait_clk(4);
    check("R9 dout cleared", {31'd0, dout}, 0);
    check("R9 word cleared", {16'd0, word_o}, 0);
    clr_n = 1'b1; wait_clk(HALF);
    check("R9 no strobe", vcnt - v0, 0);
    model = '0; exp_dout = 1'b0; exp_word = '0;
    run_frame(32'h5555, 16, 0, 1'b1, "R9 empty after clear");
  endtask

  initial begin
    clr_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; dout_rise_sel = 1'b0;
    model = '0; exp_word = '0; exp_dout = 1'b0;
    wait_clk(5);
    t_reset();
    clr_n = 1'b1; wait_clk(5);
    t_basic();
    t_modes();
    t_bursts();
    t_bad_length();
    t_deselected();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule